// File: doc/BRIEF.md
# Receive Character Buffer with Error Tags and Idle Timeout

This block sits between a serial receiver's deserializer and the host bus. Each received character arrives with three error tags, and the block stores the tags next to its 8 data bits in a ring of entries. The oldest unread entry is presented to the host as a read-only holding value. Its tags appear beside it in a small line-status word, so the tags always belong to the character the host is about to read.

The block raises two interrupt conditions, both gated by one enable input. The data-ready interrupt follows the fill level. In buffered mode it is held off until a programmable threshold is reached; in single-entry mode it fires on each character. The idle-timeout interrupt fires when unread data has been waiting and no character has arrived for a window that grows with the programmed word length: four word lengths plus twelve bit times, counted in bit-time ticks.

When buffering is switched off, the block behaves as a single holding register. Any change of the buffering mode empties the buffer.

Top module: `rx_tag_buffer`

## Requirements
- R1: After reset the buffer is empty: `hold_data` is 0, `line_stat` is 0 and both `rx_ready_irq` and `timeout_irq` are low.
- R2: With `fifo_en` high, characters leave in arrival order. `hold_data` shows the oldest unread character. Each `rd_en` pulse on a non-empty buffer removes that character, and the next one is shown from the cycle after the read edge. A read of an empty buffer changes nothing.
- R3: The tags written with a character are stored with it. `line_stat[4:2]` equals the head entry's `wr_tags[2:0]` and changes in the same cycle as `hold_data`. When the buffer is empty, both read 0.
- R4: `line_stat[0]` (data ready) is high exactly when at least one character is stored.
- R5: With `fifo_en` high, the buffer holds DEPTH characters. A write to a full buffer is dropped with the contents unchanged and sets the sticky overrun bit `line_stat[1]`. A `lsr_rd` pulse clears that bit from the next cycle, unless another write is dropped in the same cycle.
- R6: With `fifo_en` low, the buffer holds one character. A second write before a read is dropped and sets overrun. `rx_ready_irq` rises after each accepted character.
- R7: With `fifo_en` high, `rx_ready_irq` is high while the fill count is at least the threshold chosen by `trig_sel`: code 0 selects TRIG0, 1 selects TRIG1, 2 selects TRIG2 and 3 selects TRIG3.
- R8: With `rx_int_en` low, both interrupts are low. Raising `rx_int_en` shows any condition still pending.
- R9: While data is stored, `timeout_irq` rises on the L-th `bit_tick` pulse with no `wr_en` or `rd_en` since the last such event, where L = 4*(5+`word_len`)+12. The `word_len` codes 0 to 3 mean 5 to 8 bits, so L is 32, 36, 40 or 44.
- R10: A `wr_en` or `rd_en` pulse clears the timeout and restarts its count. With the buffer empty, no timeout is raised.
- R11: Any change of `fifo_en` empties the buffer: from the next cycle, data ready is low and `hold_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Character strobe from the deserializer |
| wr_data | input | 8 | Received character |
| wr_tags | input | 3 | Error tags of the character (bit 0 parity, bit 1 framing, bit 2 break) |
| rd_en | input | 1 | Host read of the holding value |
| lsr_rd | input | 1 | Host read of the line status (clears overrun) |
| fifo_en | input | 1 | 1 = buffered mode, 0 = single holding register |
| trig_sel | input | 2 | Data-ready threshold code |
| rx_int_en | input | 1 | Receive interrupt enable |
| word_len | input | 2 | Word length code, 0..3 = 5..8 bits |
| bit_tick | input | 1 | One-cycle pulse per bit time |
| hold_data | output | 8 | Oldest unread character, 0 when empty |
| line_stat | output | 5 | [0] data ready, [1] overrun, [4:2] head entry tags |
| rx_ready_irq | output | 1 | Data-ready interrupt |
| timeout_irq | output | 1 | Idle-timeout interrupt |

## Verification
The bench builds the block with DEPTH = 16 and thresholds 1, 4, 8 and 14. With these values, the full buffer and the dropped write that follows it are reached within a few dozen cycles, and the highest threshold sits two entries below full. The threshold boundary is tested by writing up to one character below the threshold and then crossing it. The timeout window is tested at both its shortest and longest length, one tick short of the limit and exactly at it.

// File: rtl/rxb_pkg.sv
// Package: shared widths and the idle-timeout length function for the
// receive character buffer. Assumes word length codes 0..3 mean 5..8 bits.
package rxb_pkg;

    localparam int RX_DATA_W = 8;
    localparam int RX_TAG_W  = 3;
    localparam int RX_ENTRY_W = RX_DATA_W + RX_TAG_W;

    // Longest idle window in bit times (8-bit words).
    localparam int TMO_MAX = 4 * 8 + 12;
    localparam int TMO_W   = $clog2(TMO_MAX + 1);

    typedef struct packed {
        logic [RX_TAG_W-1:0]  tags;
        logic [RX_DATA_W-1:0] data;
    } rx_entry_t;

    // Idle window: four word lengths plus twelve bit times.
    function automatic logic [TMO_W-1:0] tmo_limit(input logic [1:0] wl_code);
        logic [TMO_W-1:0] bits;
        bits = TMO_W'(5) + TMO_W'(wl_code);
        return TMO_W'(bits * 4 + 12);
    endfunction

endpackage

// File: rtl/rxb_store.sv
// Module: rxb_store
// Ring storage of DEPTH tagged entries with read/write pointers and an
// occupancy count. Capacity is DEPTH, or 1 when cap_one is set. A write
// when at capacity is dropped and reported on drop. The head entry is shown
// combinationally; zero when empty. flush empties the ring.
// Assumes DEPTH >= 2.
module rxb_store
    import rxb_pkg::*;
#(
    parameter int DEPTH = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              cap_one,
    input  logic              push,
    input  rx_entry_t         wdata,
    input  logic              pop,
    output rx_entry_t         head,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic              drop
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    rx_entry_t       mem [DEPTH];
    logic [AW-1:0]   wr_ptr;
    logic [AW-1:0]   rd_ptr;
    logic [CW-1:0]   cap;
    logic            accept;
    logic            pop_ok;

    // Capacity and acceptance decisions for this cycle.
    always_comb begin
        cap    = cap_one ? CW'(1) : CW'(DEPTH);
        accept = push && !flush && (count < cap);
        pop_ok = pop && !flush && (count != '0);
        drop   = push && !flush && !accept;
    end

    // Entry array write; RAM style, no reset.
    always_ff @(posedge clk) begin
        if (accept) begin
            mem[wr_ptr] <= wdata;
        end
    end

    // Pointer and occupancy update with wrap at DEPTH.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (accept) begin
                wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            end
            if (pop_ok) begin
                rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            end
            case ({accept, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // Head entry presentation, cleared when nothing is stored.
    always_comb begin
        head = (count != '0) ? mem[rd_ptr] : '0;
    end

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH)); // R5

    AST_DROP_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (drop && !pop) |=> (count == $past(count))); // R5

    AST_RD_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && !flush && count != '0) |=> (count == $past(count) - 1'b1)); // R2

    AST_RD_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && count == '0) |=> (count == '0)); // R2

endmodule

// File: rtl/rxb_ready_irq.sv
// Module: rxb_ready_irq
// Data-ready interrupt: compares the fill count with the threshold picked by
// a 2-bit code (buffered mode) or with 1 (single-entry mode), gated by the
// interrupt enable. Assumes thresholds lie in 1..DEPTH.
module rxb_ready_irq #(
    parameter int DEPTH = 128,
    parameter int TRIG0 = 8,
    parameter int TRIG1 = 32,
    parameter int TRIG2 = 64,
    parameter int TRIG3 = 120
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [$clog2(DEPTH+1)-1:0] count,
    input  logic                       fifo_en,
    input  logic [1:0]                 trig_sel,
    input  logic                       int_en,
    output logic                       irq
);
    localparam int CW = $clog2(DEPTH + 1);

    logic [CW-1:0] level;

    // Threshold selection for the current mode.
    always_comb begin
        if (!fifo_en) begin
            level = CW'(1);
        end else begin
            case (trig_sel)
                2'd0:    level = CW'(TRIG0);
                2'd1:    level = CW'(TRIG1);
                2'd2:    level = CW'(TRIG2);
                default: level = CW'(TRIG3);
            endcase
        end
    end

    // Gated threshold compare.
    always_comb begin
        irq = int_en && (count >= level);
    end

    AST_IRQ_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (count != '0)); // R7

endmodule

// File: rtl/rxb_idle_timer.sv
// Module: rxb_idle_timer
// Counts bit-time ticks while data is stored and no character or read has
// occurred; raises a sticky flag when the count reaches the limit derived
// from the word length. Any write or read strobe clears it and restarts.
// Assumes bit_tick is a one-cycle pulse.
module rxb_idle_timer
    import rxb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       flush,
    input  logic       has_data,
    input  logic       wr_seen,
    input  logic       rd_seen,
    input  logic       bit_tick,
    input  logic [1:0] word_len,
    output logic       expired
);
    logic [TMO_W-1:0] ticks;
    logic [TMO_W-1:0] limit;

    // Window length for the programmed word length.
    always_comb begin
        limit = tmo_limit(word_len);
    end

    // Tick counter and sticky expiry flag.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            ticks   <= '0;
            expired <= 1'b0;
        end else if (wr_seen || rd_seen || !has_data) begin
            ticks   <= '0;
            expired <= 1'b0;
        end else if (bit_tick && !expired) begin
            ticks <= ticks + 1'b1;
            if (ticks + 1'b1 >= limit) begin
                expired <= 1'b1;
            end
        end
    end

    AST_TMO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_seen || rd_seen) |=> !expired); // R10

    AST_TMO_TICKED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(expired) |-> $past(bit_tick)); // R9

endmodule

// File: rtl/rx_tag_buffer.sv
// Module: rx_tag_buffer (top)
// Receive character buffer with per-entry error tags, line-status word,
// threshold data-ready interrupt and idle-timeout interrupt. Any change of
// fifo_en flushes the buffer. Assumes wr_en, rd_en, lsr_rd and bit_tick are
// single-cycle strobes in the clk domain.
module rx_tag_buffer
    import rxb_pkg::*;
#(
    parameter int DEPTH = 128,
    parameter int TRIG0 = 8,
    parameter int TRIG1 = 32,
    parameter int TRIG2 = 64,
    parameter int TRIG3 = 120
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [RX_DATA_W-1:0] wr_data,
    input  logic [RX_TAG_W-1:0]  wr_tags,
    input  logic                 rd_en,
    input  logic                 lsr_rd,
    input  logic                 fifo_en,
    input  logic [1:0]           trig_sel,
    input  logic                 rx_int_en,
    input  logic [1:0]           word_len,
    input  logic                 bit_tick,
    output logic [RX_DATA_W-1:0] hold_data,
    output logic [4:0]           line_stat,
    output logic                 rx_ready_irq,
    output logic                 timeout_irq
);
    localparam int CW = $clog2(DEPTH + 1);

    logic          mode_q;
    logic          flush;
    logic          drop;
    logic          overrun;
    logic          tmo_flag;
    logic [CW-1:0] count;
    rx_entry_t     head;
    rx_entry_t     wentry;

    // Remember the buffering mode to detect a change.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= fifo_en;
        end else begin
            mode_q <= fifo_en;
        end
    end

    // Flush request and incoming entry packing.
    always_comb begin
        flush       = (fifo_en != mode_q);
        wentry.data = wr_data;
        wentry.tags = wr_tags;
    end

    rxb_store #(
        .DEPTH (DEPTH)
    ) store_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (flush),
        .cap_one (!fifo_en),
        .push    (wr_en),
        .wdata   (wentry),
        .pop     (rd_en),
        .head    (head),
        .count   (count),
        .drop    (drop)
    );

    // Sticky overrun: a dropped write sets it, a status read clears it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            overrun <= 1'b0;
        end else if (drop) begin
            overrun <= 1'b1;
        end else if (lsr_rd) begin
            overrun <= 1'b0;
        end
    end

    rxb_ready_irq #(
        .DEPTH (DEPTH),
        .TRIG0 (TRIG0),
        .TRIG1 (TRIG1),
        .TRIG2 (TRIG2),
        .TRIG3 (TRIG3)
    ) ready_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .count    (count),
        .fifo_en  (fifo_en),
        .trig_sel (trig_sel),
        .int_en   (rx_int_en),
        .irq      (rx_ready_irq)
    );

    rxb_idle_timer timer_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (flush),
        .has_data (count != '0),
        .wr_seen  (wr_en),
        .rd_seen  (rd_en),
        .bit_tick (bit_tick),
        .word_len (word_len),
        .expired  (tmo_flag)
    );

    // Host-visible outputs.
    always_comb begin
        hold_data    = head.data;
        line_stat    = {head.tags, overrun, (count != '0)};
        timeout_irq  = tmo_flag && rx_int_en;
    end

    AST_IRQ_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_int_en |-> (!rx_ready_irq && !timeout_irq)); // R8

    AST_TMO_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_irq |-> line_stat[0]); // R9

    AST_OVR_SET: assert property (@(posedge clk) disable iff (!rst_n)
        drop |=> line_stat[1]); // R5

    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !line_stat[0]); // R11

endmodule

// File: tb/rx_tag_buffer_tb_top.sv
`timescale 1ns/1ps
module rx_tag_buffer_tb_top;

    localparam int DEPTH = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [2:0] wr_tags = '0;
    logic       rd_en = 1'b0;
    logic       lsr_rd = 1'b0;
    logic       fifo_en = 1'b1;
    logic [1:0] trig_sel = 2'd1;
    logic       rx_int_en = 1'b1;
    logic [1:0] word_len = 2'd3;
    logic       bit_tick = 1'b0;
    logic [7:0] hold_data;
    logic [4:0] line_stat;
    logic       rx_ready_irq;
    logic       timeout_irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;
    logic [10:0] exp_q[$];

    always #10 clk = ~clk;

    rx_tag_buffer #(
        .DEPTH (DEPTH), .TRIG0 (1), .TRIG1 (4), .TRIG2 (8), .TRIG3 (14)
    ) dut_i (
        .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .wr_data (wr_data),
        .wr_tags (wr_tags), .rd_en (rd_en), .lsr_rd (lsr_rd),
        .fifo_en (fifo_en), .trig_sel (trig_sel), .rx_int_en (rx_int_en),
        .word_len (word_len), .bit_tick (bit_tick), .hold_data (hold_data),
        .line_stat (line_stat), .rx_ready_irq (rx_ready_irq),
        .timeout_irq (timeout_irq)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp_v);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
        end
    endtask

    // Driver: one character; pushed to the scoreboard when it should be kept.
    task automatic send(input logic [7:0] d, input logic [2:0] t, input bit keep);
        @(posedge clk); #1;
        wr_en = 1'b1; wr_data = d; wr_tags = t;
        if (keep) exp_q.push_back({t, d});
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic host_read();
        @(posedge clk); #1; rd_en = 1'b1;
        @(posedge clk); #1; rd_en = 1'b0;
    endtask

    task automatic status_read();
        @(posedge clk); #1; lsr_rd = 1'b1;
        @(posedge clk); #1; lsr_rd = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1; bit_tick = 1'b1;
            @(posedge clk); #1; bit_tick = 1'b0;
        end
    endtask

    // Monitor: compares the head against the scoreboard on each host read.
    always @(negedge clk) begin
        if (rst_n && rd_en && !done) begin
            if (exp_q.size() > 0) begin
                logic [10:0] e;
                e = exp_q.pop_front();
                chk(hold_data == e[7:0], "R2 data order", hold_data, e[7:0]);
                chk(line_stat[4:2] == e[10:8], "R3 head tags", line_stat[4:2], e[10:8]);
            end else begin
                chk(hold_data == 8'd0 && line_stat[4:2] == 3'd0, "R3 empty head",
                    {line_stat[4:2], hold_data}, 0);
            end
        end
    end

    initial begin
        #(20 * 200000);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(line_stat == 5'd0, "R1 status", line_stat, 0);
        chk(hold_data == 8'd0, "R1 data", hold_data, 0);
        chk(!rx_ready_irq && !timeout_irq, "R1 irqs", {rx_ready_irq, timeout_irq}, 0);

        // Threshold 4 (trig_sel=1)
        send(8'hA1, 3'b001, 1); send(8'h52, 3'b010, 1); send(8'h33, 3'b100, 1);
        @(negedge clk);
        chk(line_stat[0] == 1'b1, "R4 ready bit", line_stat[0], 1);
        chk(rx_ready_irq == 1'b0, "R7 below threshold", rx_ready_irq, 0);
        chk(line_stat[4:2] == 3'b001, "R3 tags of head", line_stat[4:2], 1);
        send(8'hC4, 3'b111, 1);
        @(negedge clk);
        chk(rx_ready_irq == 1'b1, "R7 at threshold", rx_ready_irq, 1);
        trig_sel = 2'd2;
        @(negedge clk);
        chk(rx_ready_irq == 1'b0, "R7 threshold code 2", rx_ready_irq, 0);
        for (int i = 0; i < 4; i++) host_read();
        @(negedge clk);
        chk(line_stat == 5'd0, "R4 empty status", line_stat, 0);
        chk(hold_data == 8'd0, "R3 empty data", hold_data, 0);
        host_read();
        send(8'h77, 3'b000, 1);
        @(negedge clk);
        chk(hold_data == 8'h77, "R2 empty read ignored", hold_data, 8'h77);
        host_read();

        // Fill to DEPTH, overrun, threshold 14
        trig_sel = 2'd3;
        for (int i = 0; i < DEPTH; i++) begin
            send(8'(8'h10 + i), 3'(i), 1);
            if (i == 12) begin
                @(negedge clk);
                chk(rx_ready_irq == 1'b0, "R7 one below code 3", rx_ready_irq, 0);
            end
        end
        @(negedge clk);
        chk(rx_ready_irq == 1'b1, "R7 code 3 reached", rx_ready_irq, 1);
        chk(line_stat[1] == 1'b0, "R5 no overrun yet", line_stat[1], 0);
        send(8'hEE, 3'b111, 0);
        @(negedge clk);
        chk(line_stat[1] == 1'b1, "R5 overrun set", line_stat[1], 1);
        chk(hold_data == 8'h10, "R5 head unchanged", hold_data, 8'h10);
        rx_int_en = 1'b0;
        @(negedge clk);
        chk(!rx_ready_irq && !timeout_irq, "R8 gated", rx_ready_irq, 0);
        rx_int_en = 1'b1;
        @(negedge clk);
        chk(rx_ready_irq == 1'b1, "R8 pending shown", rx_ready_irq, 1);
        status_read();
        @(negedge clk);
        chk(line_stat[1] == 1'b0, "R5 overrun cleared", line_stat[1], 0);
        for (int i = 0; i < DEPTH; i++) host_read();
        @(negedge clk);
        chk(line_stat[0] == 1'b0, "R5 dropped byte absent", line_stat[0], 0);

        // Timeout, 8-bit words: 44 ticks
        word_len = 2'd3;
        send(8'h5A, 3'b010, 1);
        ticks(43);
        @(negedge clk);
        chk(timeout_irq == 1'b0, "R9 one tick short (44)", timeout_irq, 0);
        ticks(1);
        @(negedge clk);
        chk(timeout_irq == 1'b1, "R9 expired at 44", timeout_irq, 1);
        host_read();
        @(negedge clk);
        chk(timeout_irq == 1'b0, "R10 cleared by read", timeout_irq, 0);
        ticks(50);
        @(negedge clk);
        chk(timeout_irq == 1'b0, "R10 empty no timeout", timeout_irq, 0);

        // Timeout, 5-bit words: 32 ticks, restarted by a write
        word_len = 2'd0;
        send(8'h01, 3'b000, 1);
        ticks(31);
        send(8'h02, 3'b001, 1);
        ticks(31);
        @(negedge clk);
        chk(timeout_irq == 1'b0, "R10 restart on write", timeout_irq, 0);
        ticks(1);
        @(negedge clk);
        chk(timeout_irq == 1'b1, "R9 expired at 32", timeout_irq, 1);

        // Mode change flushes (R11)
        @(posedge clk); #1 fifo_en = 1'b0;
        exp_q.delete();
        @(negedge clk); @(negedge clk);
        chk(line_stat[0] == 1'b0, "R11 flush status", line_stat[0], 0);
        chk(hold_data == 8'd0, "R11 flush data", hold_data, 0);
        chk(timeout_irq == 1'b0, "R11 flush timeout", timeout_irq, 0);

        // Single-entry mode (R6)
        trig_sel = 2'd3;
        send(8'h9C, 3'b101, 1);
        @(negedge clk);
        chk(rx_ready_irq == 1'b1, "R6 irq per char", rx_ready_irq, 1);
        send(8'h9D, 3'b000, 0);
        @(negedge clk);
        chk(line_stat[1] == 1'b1, "R6 second write overrun", line_stat[1], 1);
        host_read();
        @(negedge clk);
        chk(line_stat[0] == 1'b0, "R6 single entry only", line_stat[0], 0);
        status_read();
        send(8'h3E, 3'b011, 1);
        @(negedge clk);
        chk(rx_ready_irq == 1'b1, "R6 irq next char", rx_ready_irq, 1);
        host_read();

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule